// File: doc/BRIEF.md
# Flash Embedded-Operation Status Word Generator

This block builds the word a host sees when it reads a parallel flash device while a program or erase runs in the background. A command sequencer supplies the current operation state. The block also takes the most significant bit of the byte being programmed, the sector bits of the read address, the sector under erase and a read strobe. From these it returns either a status word or the normal array data.

The status word carries four bits. Bit 7 is a data-polling bit. Bit 6 is a toggle bit that changes after every completed read while an operation is busy. Bit 5 flags that the internal pulse-count limit was exceeded. Bit 2 toggles on reads of the sector being erased or suspended. The toggle state advances when a read strobe ends, so two reads in a row always return different toggle values. Whether a read returns status or array data depends on the operation state and on whether the read hits the erase sector.

Top module: `flash_status_gen`

## Requirements
- R1: With op_state at idle (code 0) or at an unused code (6 or 7), rd_data equals array_data.
- R2: In program (1), erase (2), program-timeout (4) and erase-timeout (5), bit 6 of rd_data holds steady while rd_act stays high. It inverts on the clock edge after each falling edge of rd_act, however long the strobe lasts.
- R3: In program and program-timeout, bit 7 reads as the complement of prog_msb. In erase and erase-timeout, bit 7 reads 0.
- R4: Bit 5 reads 1 in both timeout states and 0 in every other status word.
- R5: In erase, erase-timeout and erase-suspend (3), bit 2 inverts after each completed read whose rd_sect equals erase_sect. It reads as that toggle value on such reads, and reads of other sectors leave it unchanged and show 0. In program and program-timeout, bit 2 reads 0.
- R6: In erase-suspend, a read of the erase sector returns status with bit 7 at 1, bit 6 frozen at its last value and bit 2 toggling per R5. A read of any other sector returns array_data.
- R7: Status word layout: bit 7 polling, bit 6 toggle, bit 5 timeout, bit 2 sector toggle. Bits 4, 3, 1, 0 and all bits above 7 are 0.
- R8: Reset, and any cycle spent in idle or an unused code, clear both toggle states to 0. The first status read of a new operation therefore shows bits 6 and 2 at 0.
- R9: A read hits the erase sector exactly when rd_sect equals erase_sect. Neighbouring and extreme sector values do not match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_state | input | 3 | Operation state from the command sequencer |
| prog_msb | input | 1 | Bit 7 of the byte being programmed |
| rd_sect | input | SECT_W | Sector-select bits of the read address |
| erase_sect | input | SECT_W | Sector under erase or suspended |
| rd_act | input | 1 | High while a host read is in progress |
| array_data | input | DATA_W | Normal array read data |
| rd_data | output | DATA_W | Word returned to the host |

## Verification
The bench builds the block with DATA_W of 16 and SECT_W of 4. The 16-bit width lets it confirm that the upper byte of every status word is zero-filled while full array words such as 16'hA5C3 and 16'hFFFF pass through unchanged. The 4-bit sector field lets it retarget the erase sector from 5 to the top value 15 and read the adjacent sector 14, so the sector match is exercised at its boundary. A strobe held for several cycles and a reset in the middle of an operation show that the toggle advances once per completed read and restarts from 0.

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int DATA_W = 16,
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_state,
  input  logic              prog_msb,
  input  logic [SECT_W-1:0] rd_sect,
  input  logic [SECT_W-1:0] erase_sect,
  input  logic              rd_act,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [2:0] OP_PROG  = 3'd1;
  localparam logic [2:0] OP_ERASE = 3'd2;
  localparam logic [2:0] OP_SUSP  = 3'd3;
  localparam logic [2:0] OP_PTMO  = 3'd4;
  localparam logic [2:0] OP_ETMO  = 3'd5;
  localparam int         PAD_W    = DATA_W - 8;

  logic rd_q, tog6, tog2;

  wire in_sect  = (rd_sect == erase_sect);
  wire is_prog  = (op_state == OP_PROG)  || (op_state == OP_PTMO);
  wire is_erase = (op_state == OP_ERASE) || (op_state == OP_ETMO);
  wire is_susp  = (op_state == OP_SUSP);
  wire is_tmo   = (op_state == OP_PTMO)  || (op_state == OP_ETMO);
  wire busy     = is_prog | is_erase;
  wire known    = busy | is_susp;
  wire sect_op  = is_erase | is_susp;
  wire rd_end   = rd_q & ~rd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      tog6 <= 1'b0;
      tog2 <= 1'b0;
    end else begin
      rd_q <= rd_act;
      if (!known) begin
        tog6 <= 1'b0;
        tog2 <= 1'b0;
      end else if (rd_end) begin
        if (busy) tog6 <= ~tog6;
        if (sect_op && in_sect) tog2 <= ~tog2;
      end
    end
  end

  wire       poll_bit = is_prog ? ~prog_msb : is_susp;
  wire       sect_bit = sect_op & in_sect & tog2;
  wire [7:0] stat     = {poll_bit, tog6, is_tmo, 2'b00, sect_bit, 2'b00};

  assign rd_data = (!known || (is_susp && !in_sect)) ? array_data
                                                     : {{PAD_W{1'b0}}, stat};
endmodule

// File: rtl/flash_status_gen_chk.sv
module flash_status_gen_chk #(
  parameter int DATA_W = 16,
  parameter int SECT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op_state,
  input logic              prog_msb,
  input logic [SECT_W-1:0] rd_sect,
  input logic [SECT_W-1:0] erase_sect,
  input logic              rd_act,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] rd_data
);
  logic strobe_prev;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) strobe_prev <= 1'b0;
    else        strobe_prev <= rd_act;

  wire done_rd = strobe_prev && !rd_act;
  wire pgm     = (op_state == 3'd1) || (op_state == 3'd4);
  wire ers     = (op_state == 3'd2) || (op_state == 3'd5);
  wire tmo     = (op_state == 3'd4) || (op_state == 3'd5);
  wire sus     = (op_state == 3'd3);
  wire act     = pgm || ers;
  wire hit     = (rd_sect == erase_sect);
  wire stat_rd = act || (sus && hit);

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !(act || sus) |-> rd_data == array_data); // R1
  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_rd && act) |=> (!act || rd_data[6] != $past(rd_data[6]))); // R2
  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_rd && act) |=> (!act || $stable(rd_data[6]))); // R2
  AST_POLL_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    pgm |-> rd_data[7] == !prog_msb); // R3
  AST_POLL_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    ers |-> !rd_data[7]); // R3
  AST_TMO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> rd_data[5] == tmo); // R4
  AST_SECT_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    pgm |-> !rd_data[2]); // R5
  AST_SECT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (ers && !hit) |-> !rd_data[2]); // R5
  AST_SUSP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (sus && !hit) |-> rd_data == array_data); // R6
  AST_SUSP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (sus && hit) |=> (!(sus && hit) || $stable(rd_data[6]))); // R6
  AST_SUSP_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (sus && hit) |-> rd_data[7]); // R6
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> ((rd_data >> 8) == '0 && rd_data[4:3] == 2'b00 && rd_data[1:0] == 2'b00)); // R7
endmodule

bind flash_status_gen flash_status_gen_chk #(.DATA_W(DATA_W), .SECT_W(SECT_W)) i_chk (.*);

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 19;
  localparam logic [2:0] IDL = 3'd0, PRG = 3'd1, ERS = 3'd2, SUS = 3'd3, PTO = 3'd4, ETO = 3'd5;
  localparam logic [3:0] SIN = 4'h5, SOUT = 4'h1;

  // fields: op[39:37] msb[36] sect[35:32] array[31:16] expected[15:0]
  localparam logic [39:0] VEC [0:NVEC-1] = '{
    {IDL, 1'b0, SOUT, 16'hA5C3, 16'hA5C3},  // R1
    {PRG, 1'b1, SIN,  16'hA5C3, 16'h0000},  // R3 R8
    {PRG, 1'b1, SIN,  16'hA5C3, 16'h0040},  // R2
    {PRG, 1'b0, SIN,  16'hA5C3, 16'h0080},  // R3
    {IDL, 1'b0, SIN,  16'hA5C3, 16'hA5C3},  // R1
    {ERS, 1'b0, SIN,  16'hA5C3, 16'h0000},  // R8
    {ERS, 1'b0, SOUT, 16'hA5C3, 16'h0040},  // R5
    {ERS, 1'b0, SIN,  16'hA5C3, 16'h0004},  // R5
    {SUS, 1'b0, SIN,  16'hA5C3, 16'h00C0},  // R6
    {SUS, 1'b0, SIN,  16'hA5C3, 16'h00C4},  // R6
    {SUS, 1'b0, SOUT, 16'h1234, 16'h1234},  // R6
    {SUS, 1'b0, SIN,  16'hA5C3, 16'h00C0},  // R6
    {ERS, 1'b0, SIN,  16'hA5C3, 16'h0044},  // R2 R5
    {ETO, 1'b0, SIN,  16'hA5C3, 16'h0020},  // R4
    {ETO, 1'b0, SIN,  16'hA5C3, 16'h0064},  // R4
    {IDL, 1'b0, SIN,  16'hFFFF, 16'hFFFF},  // R1
    {PTO, 1'b1, SIN,  16'hA5C3, 16'h0020},  // R4
    {PTO, 1'b1, SOUT, 16'hA5C3, 16'h0060},  // R4 R7
    {IDL, 1'b0, SOUT, 16'hA5C3, 16'hA5C3}   // R1
  };

  logic        clk = 1'b0, rst_n = 1'b0, prog_msb = 1'b0, rd_act = 1'b0;
  logic [2:0]  op_state = IDL;
  logic [3:0]  rd_sect = SOUT, erase_sect = SIN;
  logic [15:0] array_data = 16'hA5C3, rd_data, got;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_gen #(.DATA_W(16), .SECT_W(4)) i_flash_status_gen (
    .clk(clk), .rst_n(rst_n), .op_state(op_state), .prog_msb(prog_msb),
    .rd_sect(rd_sect), .erase_sect(erase_sect), .rd_act(rd_act),
    .array_data(array_data), .rd_data(rd_data));

  function automatic string req_of(logic [2:0] op);
    case (op)
      PRG: return "R3";
      ERS: return "R5";
      SUS: return "R6";
      PTO, ETO: return "R4";
      default: return "R1";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setup(logic [2:0] op, logic msb, logic [3:0] sect, logic [15:0] arr);
    op_state = op; prog_msb = msb; rd_sect = sect; array_data = arr;
  endtask

  task automatic do_read(output logic [15:0] v);
    @(negedge clk); rd_act = 1'b1;
    @(negedge clk); v = rd_data; rd_act = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", rd_data, 16'hA5C3);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      setup(VEC[i][39:37], VEC[i][36], VEC[i][35:32], VEC[i][31:16]);
      do_read(got);
      check(req_of(VEC[i][39:37]), got, VEC[i][15:0]);
    end

    // R2: long strobe, no toggle until it ends
    setup(PRG, 1'b0, SIN, 16'hA5C3);
    @(negedge clk); rd_act = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); check("R2 held strobe", rd_data, 16'h0080);
    end
    rd_act = 1'b0;
    @(negedge clk);
    do_read(got); check("R2 after long strobe", got, 16'h00C0);
    do_read(got); check("R2 next read", got, 16'h0080);

    // R8: reset mid-operation restarts toggle at 0
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    do_read(got); check("R8 after reset", got, 16'h0080);

    // R1 R7: unused op code passes array data
    setup(3'd7, 1'b0, SIN, 16'h5A3C);
    do_read(got); check("R1 unused code", got, 16'h5A3C);

    // R9: sector match at top boundary
    erase_sect = 4'hF;
    setup(IDL, 1'b0, 4'hF, 16'hA5C3);
    @(negedge clk);
    setup(SUS, 1'b0, 4'hF, 16'h0F0F);
    do_read(got); check("R9 top sector hit", got, 16'h0080);
    setup(SUS, 1'b0, 4'hE, 16'h0F0F);
    do_read(got); check("R9 neighbour miss", got, 16'h0F0F);
    setup(SUS, 1'b0, 4'hF, 16'h0F0F);
    do_read(got); check("R9 R5 hit toggled", got, 16'h0084);

    finish_run();
  end
endmodule